// File: doc/BRIEF.md
# Two-Processor Shared Bus Arbiter with Snoop Backoff

This block decides which of two processors drives a shared external bus, a shared second-level cache and main memory. One processor at a time holds the "current owner" role and alone drives the bus; the other waits. The waiting processor asks for the bus on its private request line. The owner hands the bus over once it has no bus cycle in flight and holds no lock. The handover is shown as a one-cycle grant pulse to the new owner, and the roles swap on the same clock edge.

The block also keeps the two caches consistent. When the owner's access hits a clean line in the other cache, the owner is told to mark its copy shared. When the access hits a modified line in the other cache, a backoff sequence starts. The owner finishes its cycle and throws the data away. The bus then passes to the other processor, which writes the dirty line back. When that write-back cycle ends, the bus returns to the original owner, which then reruns its access. Outside logic sees one owner select that always names the current owner.

Top module: `dm_bus_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, processor 0 is the owner (owner_o=0, is_mrm_o=2'b01), and gnt_o, backoff_o and shared_o are all zero.
- R2: With no backoff in progress, suppose at a clock edge the non-owner's req_i bit is 1 and the owner's busy_i and lock_i bits are both 0. Then after that edge owner_o names the former non-owner, and gnt_o carries a one-cycle pulse on that processor's bit (bit index = processor number). The roles never swap without such a grant pulse.
- R3: No handover takes place on any edge where the owner's busy_i bit is 1 and no backoff is in progress.
- R4: No handover takes place on any edge where the owner's lock_i bit is 1 and no backoff is in progress, even when the owner is idle and the other processor is requesting.
- R5: owner_o always equals the index of the single set bit of is_mrm_o.
- R6: Suppose at an edge the non-owner's hit_i is 1, its hitm_i is 0, and the owner's busy_i is 1. Then on the next cycle shared_o has exactly the owner's bit set. In any other case shared_o is zero.
- R7: Suppose with no backoff in progress the non-owner's hitm_i is 1 while the owner's busy_i is 1. Then after that edge backoff_o has the owner's bit set, and ownership does not change on that edge.
- R8: During backoff, the bus passes to the other processor, with a grant pulse, on the first edge at which the backed-off processor's busy_i is 0. Its lock_i has no effect on this.
- R9: The writer keeps the bus until its busy_i has been seen at 1 and then at 0. One cycle later the bus returns to the backed-off processor with a grant pulse, and backoff_o clears on that same edge.
- R10: While backoff_o is nonzero, req_i has no effect and no new backoff can start.
- R11: gnt_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| req_i | input | 2 | Per-processor request for the bus |
| lock_i | input | 2 | Per-processor lock for an atomic sequence |
| busy_i | input | 2 | Per-processor flag: a bus cycle is in flight |
| hit_i | input | 2 | Per-processor flag: its cache holds the snooped line |
| hitm_i | input | 2 | Per-processor flag: its cache holds the snooped line modified |
| gnt_o | output | 2 | One-cycle grant pulse to the processor taking the bus |
| is_mrm_o | output | 2 | One-hot role: set bit marks the current owner |
| backoff_o | output | 2 | Per-processor order to discard data and wait for rerun |
| shared_o | output | 2 | Per-processor pulse to mark the snooped line shared |
| owner_o | output | 1 | Owner select for the shared bus |

## Verification
The bench holds the owner busy or locked while the other processor is requesting. A design that ignored either flag would swap roles in the middle of a cycle or break an atomic sequence. It then runs a full backoff with the owner's lock held and a request raised during the sequence. A design that waited on lock would hang there, and one that honoured the request would hand the bus over early. It checks the exact edge of the return: leaving the write-back state before the writer's cycle has risen and fallen, or clearing backoff one cycle off from the swap back, both show up as owner or backoff mismatches. Long random runs with frequent modified hits compare every output, every cycle, against a reference model.

// File: rtl/dm_arb_pkg.sv
package dm_arb_pkg;
  localparam int NM  = 2;
  localparam int IDW = (NM > 1) ? $clog2(NM) : 1;

  typedef enum logic [1:0] {
    BO_IDLE      = 2'd0,
    BO_BACKOFF   = 2'd1,
    BO_WRITEBACK = 2'd2,
    BO_RETURN    = 2'd3
  } bo_state_e;

  function automatic logic [NM-1:0] id2oh(input logic [IDW-1:0] id);
    logic [NM-1:0] v;
    v = '0;
    v[id] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dm_arb_handover.sv
module dm_arb_handover
  import dm_arb_pkg::*;
(
  input  logic [IDW-1:0] mrm,
  input  logic           fsm_idle,
  input  logic           bo_start,
  input  logic [NM-1:0]  req_i,
  input  logic [NM-1:0]  lock_i,
  input  logic [NM-1:0]  busy_i,
  output logic           take_req
);
  logic [IDW-1:0] lrm;

  always_comb begin
    lrm      = ~mrm;
    // A pending snoop backoff outranks a plain request.
    take_req = fsm_idle && !bo_start && req_i[lrm] &&
               !lock_i[mrm] && !busy_i[mrm];
  end
endmodule

// File: rtl/dm_arb_backoff_fsm.sv
module dm_arb_backoff_fsm
  import dm_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] mrm,
  input  logic [NM-1:0]  busy_i,
  input  logic [NM-1:0]  hitm_i,
  output logic           bo_start,
  output logic           bo_swap,
  output logic           fsm_idle,
  output logic [NM-1:0]  backoff_o
);
  bo_state_e      state_q, state_d;
  logic [IDW-1:0] orig_q, orig_d;
  logic           seen_q, seen_d;
  logic [IDW-1:0] lrm, writer;

  always_comb begin
    lrm      = ~mrm;
    writer   = ~orig_q;
    state_d  = state_q;
    orig_d   = orig_q;
    seen_d   = seen_q;
    bo_swap  = 1'b0;
    bo_start = 1'b0;
    unique case (state_q)
      BO_IDLE: begin
        if (hitm_i[lrm] && busy_i[mrm]) begin
          bo_start = 1'b1;
          orig_d   = mrm;
          state_d  = BO_BACKOFF;
        end
      end
      BO_BACKOFF: begin
        // Lock is not consulted: the dirty line must be written back.
        if (!busy_i[orig_q]) begin
          bo_swap = 1'b1;
          seen_d  = 1'b0;
          state_d = BO_WRITEBACK;
        end
      end
      BO_WRITEBACK: begin
        if (seen_q && !busy_i[writer]) state_d = BO_RETURN;
        else if (busy_i[writer])       seen_d  = 1'b1;
      end
      BO_RETURN: begin
        bo_swap = 1'b1;
        state_d = BO_IDLE;
      end
      default: state_d = BO_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BO_IDLE;
      orig_q  <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      orig_q  <= orig_d;
      seen_q  <= seen_d;
    end
  end

  always_comb begin
    fsm_idle  = (state_q == BO_IDLE);
    backoff_o = fsm_idle ? '0 : id2oh(orig_q);
  end
endmodule

// File: rtl/dm_arb_role_reg.sv
module dm_arb_role_reg
  import dm_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           swap,
  output logic [IDW-1:0] mrm,
  output logic [NM-1:0]  gnt_o
);
  logic [IDW-1:0] mrm_d;
  logic [NM-1:0]  gnt_d;

  always_comb begin
    mrm_d = mrm;
    gnt_d = '0;
    if (swap) begin
      mrm_d = ~mrm;
      gnt_d = id2oh(~mrm);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrm   <= '0;
      gnt_o <= '0;
    end else begin
      mrm   <= mrm_d;
      gnt_o <= gnt_d;
    end
  end
endmodule

// File: rtl/dm_bus_arbiter.sv
module dm_bus_arbiter
  import dm_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NM-1:0]  req_i,
  input  logic [NM-1:0]  lock_i,
  input  logic [NM-1:0]  busy_i,
  input  logic [NM-1:0]  hit_i,
  input  logic [NM-1:0]  hitm_i,
  output logic [NM-1:0]  gnt_o,
  output logic [NM-1:0]  is_mrm_o,
  output logic [NM-1:0]  backoff_o,
  output logic [NM-1:0]  shared_o,
  output logic [IDW-1:0] owner_o
);
  logic [IDW-1:0] mrm;
  logic           fsm_idle, bo_start, bo_swap, take_req;
  logic [NM-1:0]  shared_d;

  dm_arb_backoff_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mrm(mrm), .busy_i(busy_i), .hitm_i(hitm_i),
    .bo_start(bo_start), .bo_swap(bo_swap), .fsm_idle(fsm_idle),
    .backoff_o(backoff_o)
  );

  dm_arb_handover u_hand (
    .mrm(mrm), .fsm_idle(fsm_idle), .bo_start(bo_start), .req_i(req_i),
    .lock_i(lock_i), .busy_i(busy_i), .take_req(take_req)
  );

  dm_arb_role_reg u_role (
    .clk(clk), .rst_n(rst_n), .swap(take_req | bo_swap),
    .mrm(mrm), .gnt_o(gnt_o)
  );

  // Clean hit in the other cache: owner downgrades its copy.
  always_comb begin
    shared_d = '0;
    if (hit_i[~mrm] && !hitm_i[~mrm] && busy_i[mrm]) shared_d = id2oh(mrm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shared_o <= '0;
    else        shared_o <= shared_d;
  end

  for (genvar g = 0; g < NM; g++) begin : g_role
    assign is_mrm_o[g] = (mrm == IDW'(g));
  end

  assign owner_o = mrm;
endmodule

// File: rtl/dm_bus_arbiter_chk.sv
module dm_bus_arbiter_chk
  import dm_arb_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NM-1:0]  lock_i,
  input logic [NM-1:0]  busy_i,
  input logic [NM-1:0]  gnt_o,
  input logic [NM-1:0]  is_mrm_o,
  input logic [NM-1:0]  backoff_o,
  input logic [NM-1:0]  shared_o,
  input logic [IDW-1:0] owner_o
);
  a_r5_owner_matches_role: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(is_mrm_o) && is_mrm_o[owner_o]);

  a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r2_grant_goes_to_new_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_o) |-> (gnt_o[owner_o] && owner_o != $past(owner_o)));

  a_r2_swap_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_o != $past(owner_o)) |-> (|gnt_o));

  a_r3_busy_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i[owner_o] && backoff_o == '0) |=> (owner_o == $past(owner_o)));

  a_r4_lock_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i[owner_o] && backoff_o == '0) |=> (owner_o == $past(owner_o)));

  a_r7_backoff_hits_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|backoff_o) |-> (backoff_o[owner_o] && $stable(owner_o)));

  a_r9_bus_returned: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|backoff_o) |-> (gnt_o[owner_o] && owner_o != $past(owner_o)));

  a_r6_shared_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(shared_o) && $onehot0(backoff_o));
endmodule

bind dm_bus_arbiter dm_bus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .busy_i(busy_i),
  .gnt_o(gnt_o), .is_mrm_o(is_mrm_o), .backoff_o(backoff_o),
  .shared_o(shared_o), .owner_o(owner_o)
);

// File: tb/dm_bus_arbiter_tb.sv
module dm_bus_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [1:0] req_i, lock_i, busy_i, hit_i, hitm_i;
  logic [1:0] gnt_o, is_mrm_o, backoff_o, shared_o;
  logic       owner_o;

  int checks, failures;

  // reference model state
  logic       m_mrm, m_orig, m_seen;
  int         m_st;
  logic [1:0] m_gnt, m_shared;

  dm_bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
    .busy_i(busy_i), .hit_i(hit_i), .hitm_i(hitm_i), .gnt_o(gnt_o),
    .is_mrm_o(is_mrm_o), .backoff_o(backoff_o), .shared_o(shared_o),
    .owner_o(owner_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] oh(input logic id);
    return id ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] exp_backoff();
    return (m_st != 0) ? oh(m_orig) : 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mrm = 1'b0; m_orig = 1'b0; m_seen = 1'b0; m_st = 0;
      m_gnt = 2'b00; m_shared = 2'b00;
    end else begin
      logic lrm, swap;
      lrm  = ~m_mrm;
      swap = 1'b0;
      m_shared = (hit_i[lrm] && !hitm_i[lrm] && busy_i[m_mrm]) ? oh(m_mrm) : 2'b00;
      case (m_st)
        0: if (hitm_i[lrm] && busy_i[m_mrm]) begin m_st = 1; m_orig = m_mrm; end
           else if (req_i[lrm] && !lock_i[m_mrm] && !busy_i[m_mrm]) swap = 1'b1;
        1: if (!busy_i[m_orig]) begin swap = 1'b1; m_st = 2; m_seen = 1'b0; end
        2: if (m_seen && !busy_i[~m_orig]) m_st = 3;
           else if (busy_i[~m_orig]) m_seen = 1'b1;
        default: begin swap = 1'b1; m_st = 0; end
      endcase
      m_gnt = swap ? oh(~m_mrm) : 2'b00;
      if (swap) m_mrm = ~m_mrm;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(owner_o == m_mrm, "R5 owner", owner_o, m_mrm);
    chk(is_mrm_o == oh(m_mrm), "R5 role", is_mrm_o, oh(m_mrm));
    chk(gnt_o == m_gnt, "R2/R11 grant", gnt_o, m_gnt);
    chk(backoff_o == exp_backoff(), "R7/R9 backoff", backoff_o, exp_backoff());
    chk(shared_o == m_shared, "R6 shared", shared_o, m_shared);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_i = 0; lock_i = 0; busy_i = 0; hit_i = 0; hitm_i = 0;
    repeat (3) @(negedge clk);
    chk(owner_o == 1'b0 && is_mrm_o == 2'b01, "R1 reset owner", is_mrm_o, 1);
    rst_n = 1'b1;
    step();
    chk(gnt_o == 0 && backoff_o == 0 && shared_o == 0 && owner_o == 0,
        "R1 after reset", {gnt_o, backoff_o, shared_o}, 0);

    // R3: owner busy blocks the request
    req_i = 2'b10; busy_i = 2'b01;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(owner_o == 0 && gnt_o == 0, "R3 busy blocks", owner_o, 0);
    end
    // R4: lock blocks the request even when idle
    busy_i = 2'b00; lock_i = 2'b01;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(owner_o == 0 && gnt_o == 0, "R4 lock blocks", owner_o, 0);
    end
    // R2: handover with one-cycle grant
    lock_i = 2'b00;
    step();
    chk(gnt_o == 2'b10 && owner_o == 1 && is_mrm_o == 2'b10, "R2 handover",
        {gnt_o, is_mrm_o}, 4'b1010);
    req_i = 2'b00;
    step();
    chk(gnt_o == 2'b00 && owner_o == 1, "R2 grant pulse", gnt_o, 0);
    // R6: clean hit marks owner's line shared
    busy_i = 2'b10; hit_i = 2'b01;
    step();
    chk(shared_o == 2'b10, "R6 shared pulse", shared_o, 2'b10);
    hit_i = 2'b00;
    // R7: modified hit starts backoff on owner 1
    hitm_i = 2'b01;
    step();
    chk(backoff_o == 2'b10 && owner_o == 1 && gnt_o == 0, "R7 backoff start",
        backoff_o, 2'b10);
    hitm_i = 2'b00; req_i = 2'b01; lock_i = 2'b10;
    step();
    chk(owner_o == 1 && gnt_o == 0, "R10 request ignored", owner_o, 1);
    // R8: handover once owner's cycle ends, lock ignored
    busy_i = 2'b00;
    step();
    chk(owner_o == 0 && gnt_o == 2'b01 && backoff_o == 2'b10, "R8 to writer",
        {gnt_o, backoff_o}, 4'b0110);
    req_i = 2'b00; lock_i = 2'b00;
    step();
    chk(owner_o == 0 && backoff_o == 2'b10, "R9 waits for write-back", owner_o, 0);
    // R9: write-back cycle rises and falls
    busy_i = 2'b01; hitm_i = 2'b10;
    step();
    chk(owner_o == 0 && backoff_o == 2'b10, "R10 no new backoff", backoff_o, 2'b10);
    hitm_i = 2'b00;
    step();
    busy_i = 2'b00;
    step();
    chk(owner_o == 0 && backoff_o == 2'b10 && gnt_o == 0, "R9 return pending",
        {owner_o, backoff_o}, 3'b010);
    step();
    chk(owner_o == 1 && gnt_o == 2'b10 && backoff_o == 2'b00, "R9 bus returned",
        {gnt_o, backoff_o}, 4'b1000);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      req_i  = 2'($urandom);
      lock_i = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      busy_i = 2'($urandom);
      hit_i  = 2'($urandom);
      hitm_i = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      step();
      chk($countones(gnt_o) <= 1, "R11 single grant", gnt_o, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule